// File: doc/BRIEF.md
# Banked GPIO Controller with Per-Group Drive Gating

This block controls up to sixty-four general-purpose pad lines. The lines are split into eight groups of eight. Line n sits in group n/8 at bit n%8. Direction and function selection are held in indexed configuration registers. Pad data moves through a separate runtime byte window whose start address is programmable. Configuration software sets which lines drive and moves the window. Runtime software then reads pad levels and writes output values one group byte at a time.

A line drives its pad only when two conditions hold: its output-enable bit is set, and its group's function gate allows it. The first five groups each have a simple-I/O gate register that must enable the line. The remaining groups have no gate and count as always in GPIO mode. Output values are latched whatever the direction, so a value written while a line is an input appears on the pad as soon as the line becomes an output.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset all output-enable bits, simple-I/O gate bits and output latches are 0, the window base equals the BASE_RESET parameter (0x0A00), and no pad is driven.
- R2: A configuration write to index 0xC8+g (g from 0 to 7) stores the output-enable byte of group g, and a configuration read of that index returns it. Bit b (1 = drive) controls line 8g+b.
- R3: Configuration indices 0xC0 to 0xC4 hold the simple-I/O gate bytes of groups 0 to 4 and read back what was written. Indices 0xC5 to 0xC7, and any other index that is not listed, read as 0 and ignore writes.
- R4: pad_oe for line 8g+b is 1 exactly when the output-enable bit is set and the line is gated on. A line is gated on when its simple-I/O bit is 1 for g < 5, and always for g >= 5.
- R5: A runtime write to address base+g (g from 0 to 7) loads the output latch of group g, and pad_out shows the new byte from the next clock cycle on.
- R6: A runtime read of base+g returns the pad_in levels of group g in the same cycle, with io_rvalid high. It does not return the output latch.
- R7: A runtime access with an address outside base to base+7 changes no latch, leaves io_rvalid low and returns 0 on io_rdata.
- R8: Configuration index 0x62 holds the high byte of the window base and index 0x63 holds the low byte. Both read back, and a new value moves the runtime window from the next cycle on.
- R9: The output latch holds its value whatever the direction of the line: after data is written to an input line, setting the line's enable puts that value on pad_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 8 | Configuration register index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data for cfg_idx_i (combinational) |
| io_addr_i | input | 16 | Runtime bus address |
| io_wr_i | input | 1 | Runtime write strobe |
| io_rd_i | input | 1 | Runtime read strobe |
| io_wdata_i | input | 8 | Runtime write data |
| io_rdata_o | output | 8 | Runtime read data, 0 when not decoded |
| io_rvalid_o | output | 1 | High when a runtime read hits the window |
| pad_in_i | input | 64 | Pad input levels |
| pad_out_o | output | 64 | Pad output values |
| pad_oe_o | output | 64 | Pad drive enables |

## Verification
Random configuration writes go to the enable, gate, base and unmapped indices, mixed with random runtime accesses that land inside the window, just below it and just above it. These separate three kinds of fault: an enable that is dropped, a gate that is applied to the wrong groups, and an address decode that is off by one. Directed cases move the base and probe both the old and the new window. They drive pad levels that differ from the latch, so a read that returns the latch shows up as a fault. They also write data to input lines before enabling them, which shows whether the latch is kept while a line is an input.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned GRP_W = 8;
    typedef logic [GRP_W-1:0] gbyte_t;
    localparam gbyte_t IDX_SEL_DEF  = 8'hC0;
    localparam gbyte_t IDX_OE_DEF   = 8'hC8;
    localparam gbyte_t IDX_BHI_DEF  = 8'h62;
    localparam gbyte_t IDX_BLO_DEF  = 8'h63;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GROUPS   = 8,
    parameter int unsigned SEL_GROUPS = 5,
    parameter gbyte_t      IDX_SEL    = IDX_SEL_DEF,
    parameter gbyte_t      IDX_OE     = IDX_OE_DEF,
    parameter gbyte_t      IDX_BHI    = IDX_BHI_DEF,
    parameter gbyte_t      IDX_BLO    = IDX_BLO_DEF,
    parameter logic [15:0] BASE_RESET = 16'h0A00
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      we_i,
    input  gbyte_t                    idx_i,
    input  gbyte_t                    wdata_i,
    output gbyte_t                    rdata_o,
    output logic [N_GROUPS-1:0][7:0]  oe_o,
    output logic [N_GROUPS-1:0][7:0]  sel_o,
    output logic [15:0]               base_o
);
    typedef struct packed {
        logic [N_GROUPS-1:0][7:0]   oe;
        logic [SEL_GROUPS-1:0][7:0] sel;
        logic [15:0]                base;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rdata_o = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (idx_i == gbyte_t'(IDX_OE + g)) begin
                rdata_o = st_q.oe[g];
                if (we_i) st_d.oe[g] = wdata_i;
            end
        end
        for (int g = 0; g < SEL_GROUPS; g++) begin
            if (idx_i == gbyte_t'(IDX_SEL + g)) begin
                rdata_o = st_q.sel[g];
                if (we_i) st_d.sel[g] = wdata_i;
            end
        end
        if (idx_i == IDX_BHI) begin
            rdata_o = st_q.base[15:8];
            if (we_i) st_d.base[15:8] = wdata_i;
        end
        if (idx_i == IDX_BLO) begin
            rdata_o = st_q.base[7:0];
            if (we_i) st_d.base[7:0] = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.base <= BASE_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign oe_o   = st_q.oe;
    assign base_o = st_q.base;

    generate
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_sel_out
            if (g < SEL_GROUPS) begin : g_has
                assign sel_o[g] = st_q.sel[g];
            end else begin : g_none
                assign sel_o[g] = '0;
            end
        end
    endgenerate

    generate
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk_oe
            p_oe_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (we_i && idx_i == gbyte_t'(IDX_OE + g)) |=> (oe_o[g] == $past(wdata_i)));
        end
    endgenerate

    p_base_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && idx_i == IDX_BHI) |=> (base_o[15:8] == $past(wdata_i)));

    p_no_gate_reg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (idx_i >= gbyte_t'(IDX_SEL + SEL_GROUPS) && idx_i < IDX_OE) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_rt_port.sv
module gpio_rt_port
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GROUPS = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [15:0]              base_i,
    input  logic [15:0]              addr_i,
    input  logic                     wr_i,
    input  logic                     rd_i,
    input  gbyte_t                   wdata_i,
    output gbyte_t                   rdata_o,
    output logic                     rvalid_o,
    input  logic [N_GROUPS-1:0][7:0] pad_in_i,
    output logic [N_GROUPS-1:0][7:0] out_o
);
    localparam int unsigned OFF_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;

    typedef struct packed {
        logic [N_GROUPS-1:0][7:0] out;
    } rt_state_t;

    rt_state_t   st_d, st_q;
    logic [15:0] off;
    logic        hit;

    always_comb begin
        off      = addr_i - base_i;
        hit      = (off < 16'(N_GROUPS));
        st_d     = st_q;
        rdata_o  = '0;
        rvalid_o = 1'b0;
        if (hit && wr_i) st_d.out[off[OFF_W-1:0]] = wdata_i;
        if (hit && rd_i) begin
            rdata_o  = pad_in_i[off[OFF_W-1:0]];
            rvalid_o = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_o = st_q.out;

    p_no_stray_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !hit) |=> $stable(out_o));

    p_stray_read_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hit |-> (!rvalid_o && rdata_o == '0));

    p_latch_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && hit) |=> (out_o[$past(off[OFF_W-1:0])] == $past(wdata_i)));
endmodule

// File: rtl/gpio_pad_gate.sv
module gpio_pad_gate #(
    parameter int unsigned N_GROUPS   = 8,
    parameter int unsigned SEL_GROUPS = 5
) (
    input  logic [N_GROUPS-1:0][7:0] oe_i,
    input  logic [N_GROUPS-1:0][7:0] sel_i,
    output logic [N_GROUPS-1:0][7:0] pad_oe_o
);
    generate
        for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
            if (g < SEL_GROUPS) begin : g_gated
                assign pad_oe_o[g] = oe_i[g] & sel_i[g];
            end else begin : g_free
                assign pad_oe_o[g] = oe_i[g];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned N_GROUPS   = 8,
    parameter int unsigned SEL_GROUPS = 5,
    parameter logic [15:0] BASE_RESET = 16'h0A00,
    localparam int unsigned N_LINES   = N_GROUPS * GRP_W
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               cfg_we_i,
    input  logic [7:0]         cfg_idx_i,
    input  logic [7:0]         cfg_wdata_i,
    output logic [7:0]         cfg_rdata_o,
    input  logic [15:0]        io_addr_i,
    input  logic               io_wr_i,
    input  logic               io_rd_i,
    input  logic [7:0]         io_wdata_i,
    output logic [7:0]         io_rdata_o,
    output logic               io_rvalid_o,
    input  logic [N_LINES-1:0] pad_in_i,
    output logic [N_LINES-1:0] pad_out_o,
    output logic [N_LINES-1:0] pad_oe_o
);
    logic [N_GROUPS-1:0][7:0] oe_w, sel_w, out_w, pad_oe_w, pad_in_w;
    logic [15:0]              base_w;

    assign pad_in_w = pad_in_i;

    gpio_cfg_regs #(
        .N_GROUPS  (N_GROUPS),
        .SEL_GROUPS(SEL_GROUPS),
        .BASE_RESET(BASE_RESET)
    ) u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cfg_we_i),
        .idx_i  (cfg_idx_i),
        .wdata_i(cfg_wdata_i),
        .rdata_o(cfg_rdata_o),
        .oe_o   (oe_w),
        .sel_o  (sel_w),
        .base_o (base_w)
    );

    gpio_rt_port #(.N_GROUPS(N_GROUPS)) u_rt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .base_i  (base_w),
        .addr_i  (io_addr_i),
        .wr_i    (io_wr_i),
        .rd_i    (io_rd_i),
        .wdata_i (io_wdata_i),
        .rdata_o (io_rdata_o),
        .rvalid_o(io_rvalid_o),
        .pad_in_i(pad_in_w),
        .out_o   (out_w)
    );

    gpio_pad_gate #(.N_GROUPS(N_GROUPS), .SEL_GROUPS(SEL_GROUPS)) u_gate (
        .oe_i    (oe_w),
        .sel_i   (sel_w),
        .pad_oe_o(pad_oe_w)
    );

    assign pad_out_o = out_w;
    assign pad_oe_o  = pad_oe_w;

    p_gate_subset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((pad_oe_o & ~N_LINES'(oe_w)) == '0));

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |-> (pad_oe_o == '0 && pad_out_o == '0));
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
module gpio_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0, cfg_wdata = '0, cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0, io_rdata;
    logic        io_rvalid;
    logic [63:0] pad_in = '0, pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m_oe  [8];
    logic [7:0]  m_sel [5];
    logic [7:0]  m_out [8];
    logic [15:0] m_base;

    always #10 clk = ~clk;

    gpio_bank_ctrl u_gpio_bank_ctrl (
        .clk_i(clk), .rst_ni(rst_n),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd), .io_wdata_i(io_wdata),
        .io_rdata_o(io_rdata), .io_rvalid_o(io_rvalid),
        .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_oe();
        logic [63:0] v = '0;
        for (int g = 0; g < 8; g++) v[g*8 +: 8] = m_oe[g] & ((g < 5) ? m_sel[g] : 8'hFF);
        return v;
    endfunction

    function automatic logic [63:0] exp_out();
        logic [63:0] v = '0;
        for (int g = 0; g < 8; g++) v[g*8 +: 8] = m_out[g];
        return v;
    endfunction

    function automatic logic [7:0] exp_cfg(logic [7:0] idx);
        if (idx >= 8'hC8 && idx <= 8'hCF) return m_oe[idx - 8'hC8];
        if (idx >= 8'hC0 && idx <= 8'hC4) return m_sel[idx - 8'hC0];
        if (idx == 8'h62) return m_base[15:8];
        if (idx == 8'h63) return m_base[7:0];
        return 8'h00;
    endfunction

    task automatic cfg_wr(logic [7:0] idx, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx >= 8'hC8 && idx <= 8'hCF) m_oe[idx - 8'hC8] = d;
        else if (idx >= 8'hC0 && idx <= 8'hC4) m_sel[idx - 8'hC0] = d;
        else if (idx == 8'h62) m_base[15:8] = d;
        else if (idx == 8'h63) m_base[7:0] = d;
    endtask

    task automatic cfg_rd_chk(string req, logic [7:0] idx);
        @(negedge clk);
        cfg_idx = idx;
        #2;
        chk(req, 64'(cfg_rdata), 64'(exp_cfg(idx)));
    endtask

    task automatic io_wr_t(logic [15:0] a, logic [7:0] d);
        logic [15:0] off;
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
        off = a - m_base;
        if (off < 16'd8) m_out[off[2:0]] = d;
    endtask

    task automatic io_rd_chk(string req, logic [15:0] a);
        logic [15:0] off;
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #2;
        off = a - m_base;
        if (off < 16'd8) begin
            chk(req, 64'(io_rdata), 64'(pad_in[off[2:0]*8 +: 8]));
            chk(req, 64'(io_rvalid), 64'd1);
        end else begin
            chk(req, 64'(io_rdata), 64'd0);
            chk(req, 64'(io_rvalid), 64'd0);
        end
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic pads_chk(string req);
        #1;
        chk({req, " pad_oe"}, pad_oe, exp_oe());
        chk({req, " pad_out"}, pad_out, exp_out());
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int g = 0; g < 8; g++) begin m_oe[g] = '0; m_out[g] = '0; end
        for (int g = 0; g < 5; g++) m_sel[g] = '0;
        m_base = 16'h0A00;
        repeat (3) @(negedge clk);
        // R1: reset state
        pads_chk("R1");
        rst_n = 1'b1;
        @(negedge clk);
        pads_chk("R1");
        cfg_rd_chk("R1", 8'hC8);
        cfg_rd_chk("R1", 8'h62);
        cfg_rd_chk("R1", 8'h63);

        // R9: latch held while line is input, appears once enabled
        io_wr_t(16'h0A06, 8'h5A);
        pads_chk("R9");
        cfg_wr(8'hCE, 8'hF0);
        pads_chk("R9");

        // R4: gated group needs the simple-I/O bit; group 5+ needs none
        cfg_wr(8'hC9, 8'hFF);
        pads_chk("R4");
        cfg_wr(8'hC1, 8'h3C);
        pads_chk("R4");
        cfg_wr(8'hCD, 8'h81);
        pads_chk("R4");

        // R3: absent gate registers read 0 and ignore writes
        cfg_wr(8'hC5, 8'hFF);
        cfg_rd_chk("R3", 8'hC5);
        cfg_rd_chk("R3", 8'hC7);
        cfg_wr(8'h30, 8'hAA);
        cfg_rd_chk("R3", 8'h30);
        pads_chk("R3");

        // R6: reads return pad levels, not the latch
        pad_in = 64'h0123_4567_89AB_CDEF;
        io_rd_chk("R6", 16'h0A06);
        io_rd_chk("R6", 16'h0A00);
        io_rd_chk("R6", 16'h0A07);

        // R7: window edges
        io_rd_chk("R7", 16'h09FF);
        io_rd_chk("R7", 16'h0A08);
        io_wr_t(16'h0A08, 8'hEE);
        pads_chk("R7");
        io_wr_t(16'h09FF, 8'hEE);
        pads_chk("R7");

        // R8: move the window
        cfg_wr(8'h62, 8'h0B);
        cfg_wr(8'h63, 8'h10);
        cfg_rd_chk("R8", 8'h62);
        cfg_rd_chk("R8", 8'h63);
        io_wr_t(16'h0A00, 8'h77);
        pads_chk("R8");
        io_wr_t(16'h0B17, 8'h99);
        pads_chk("R8");
        io_rd_chk("R8", 16'h0B10);

        // R5: write to each group
        for (int g = 0; g < 8; g++) begin
            io_wr_t(m_base + 16'(g), 8'(8'h11 * (g + 1)));
            pads_chk("R5");
        end

        // R2: random enable, gate, base and runtime traffic
        for (int it = 0; it < 600; it++) begin
            int unsigned op = $urandom % 6;
            pad_in = {$urandom, $urandom};
            case (op)
                0: begin
                    logic [7:0] ix = 8'hC8 + 8'($urandom % 8);
                    cfg_wr(ix, 8'($urandom));
                    cfg_rd_chk("R2", ix);
                end
                1: begin
                    logic [7:0] ix = 8'hC0 + 8'($urandom % 8);
                    cfg_wr(ix, 8'($urandom));
                    cfg_rd_chk("R3", ix);
                end
                2: begin
                    if ($urandom % 2 == 0) cfg_wr(8'h62, 8'h0A + 8'($urandom % 3));
                    else cfg_wr(8'h63, 8'($urandom));
                    cfg_rd_chk("R8", ($urandom % 2 == 0) ? 8'h62 : 8'h63);
                end
                3, 4: io_wr_t(m_base + 16'($urandom % 12) - 16'd2, 8'($urandom));
                default: io_rd_chk("R6", m_base + 16'($urandom % 12) - 16'd2);
            endcase
            pads_chk("R4");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule